// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 16 bits. The RAM has active-low chip, write and output enables and one active-low select per byte lane. The host issues one read or one write at a time on a valid/ready port. Each request carries a word address, write data, a byte-enable mask and a direction bit. A read result comes back on a one-cycle valid strobe.

Every asynchronous limit is given as a parameter in picoseconds, together with the clock period. The block turns each limit into a whole number of clock cycles, rounding up. Write enable only falls once the address and the lane selects are settled. It rises again before any of them moves. The block drives the data bus only inside a write, and only on the lanes the host enabled. A write that follows a read waits with the chip deselected, so the RAM's output drivers can let go of the bus first. Outside the chip the data bus is split into an output value, a per-lane drive enable and an input value. The board-level tristate buffer joins them.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, ready is high and chip, write and output enables and both lane selects are high (inactive). No lane is driven and no read result is flagged.
- R2: A read holds chip enable low, output enable low and write enable high. When it ends, rsp_valid is high for exactly one cycle, carrying the captured word. A write never raises rsp_valid.
- R3: A write holds write enable low for WP cycles, where WP = max(ceil(tWP/Tclk), ceil(tDW/Tclk)). This happens with chip enable low and output enable high, after one cycle in which chip enable is low and write enable is still high.
- R4: The data bus is driven only while chip enable is low and output enable is high, and only on enabled lanes. The write value is driven in every cycle that write enable is low.
- R5: The address and the lane selects do not change while chip enable stays low. In particular, they do not change while write enable is low.
- R6: Lane select bit 0 gates data bits 7..0 and bit 1 gates bits 15..8. Select bit i is low during an access exactly when req_be[i] is 1.
- R7: A write accepted directly after a read spends ceil(tOHZ/Tclk) extra cycles with chip enable high, before its setup cycle.
- R8: A write keeps ready low for 1 + WP + max(1, ceil(tWC/Tclk) - 1 - WP) cycles after acceptance. Ready is only high while chip enable is high and nothing is driven.
- R9: A read keeps ready low for ceil(tAA/Tclk) cycles after acceptance. The data is sampled at the edge that ends that count.
- R10: On a read, lanes whose enable bit is 0 return zero, whatever the bus carries on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write value |
| req_be | input | DATA_W/8 | Lane enable mask, bit i for bits 8i+7..8i |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_data | output | DATA_W | Read result, disabled lanes zero |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | DATA_W/8 | Lane selects, active low |
| mem_dq_out | output | DATA_W | Value for the bus driver |
| mem_dq_oe | output | DATA_W/8 | Per-lane bus driver enable |
| mem_dq_in | input | DATA_W | Value read from the bus |

## Verification
The hardest case to reach from the ports is a read result that is sampled too early. A short access count would still return the right data from any instant RAM model. The bench's RAM model therefore tracks, at each falling clock edge, how many cycles the read strobes and address have stayed unchanged. It returns a poison byte until ceil(tAA/Tclk) cycles have passed. The model also measures each write-enable pulse and the cycles of driven data ahead of it, and stores only the lanes actually driven. A full address sweep mixes lane masks and alternates writes and reads back to back. This brings in the turnaround path on every write and checks the occupancy of each request type.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSETUP,
    ST_WSTROBE,
    ST_WRECOV,
    ST_READ
  } seq_state_t;

  // whole clock cycles covering a time limit, never fewer than one
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int BE_W   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              drive_nxt,
  input  logic [BE_W-1:0]   lane_en_nxt,
  input  logic              capture,
  input  logic [BE_W-1:0]   lane_en_q,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [BE_W-1:0]   mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] cap_val;

  // lanes not selected for the read come back as zero
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign cap_val[i*LANE_W +: LANE_W] =
      lane_en_q[i] ? mem_dq_in[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_dq_out <= '0;
      mem_dq_oe  <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      if (accept) mem_dq_out <= req_wdata;
      mem_dq_oe <= drive_nxt ? lane_en_nxt : '0;
      rsp_valid <= capture;
      if (capture) rsp_data <= cap_val;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BE_W    = 2,
  parameter int CNT_W   = 4,
  parameter int AA_CYC  = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1,
  parameter int OHZ_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [BE_W-1:0]   mem_bsel_n,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  input  logic              timer_zero,
  output logic              accept,
  output logic              drive_nxt,
  output logic [BE_W-1:0]   lane_en_nxt,
  output logic              capture,
  output logic [BE_W-1:0]   lane_en_q
);

  seq_state_t st_q, st_nxt;
  logic       last_rd_q;
  logic       active_nxt;

  always_comb begin
    st_nxt     = st_q;
    timer_load = 1'b0;
    timer_val  = '0;
    accept     = 1'b0;
    capture    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          timer_load = 1'b1;
          if (req_write && last_rd_q) begin
            st_nxt    = ST_TURN;
            timer_val = CNT_W'(OHZ_CYC - 1);
          end else if (req_write) begin
            st_nxt    = ST_WSETUP;
          end else begin
            st_nxt    = ST_READ;
            timer_val = CNT_W'(AA_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (timer_zero) begin
          st_nxt     = ST_WSETUP;
          timer_load = 1'b1;
        end
      end
      ST_WSETUP: begin
        if (timer_zero) begin
          st_nxt     = ST_WSTROBE;
          timer_load = 1'b1;
          timer_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WSTROBE: begin
        if (timer_zero) begin
          st_nxt     = ST_WRECOV;
          timer_load = 1'b1;
          timer_val  = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WRECOV: begin
        if (timer_zero) st_nxt = ST_IDLE;
      end
      ST_READ: begin
        if (timer_zero) begin
          st_nxt  = ST_IDLE;
          capture = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign active_nxt  = (st_nxt != ST_IDLE) && (st_nxt != ST_TURN);
  assign lane_en_nxt = accept ? req_be : lane_en_q;
  assign drive_nxt   = (st_nxt == ST_WSTROBE) || (st_nxt == ST_WRECOV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      last_rd_q  <= 1'b0;
      req_ready  <= 1'b1;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_bsel_n <= '1;
      lane_en_q  <= '0;
    end else begin
      st_q       <= st_nxt;
      req_ready  <= (st_nxt == ST_IDLE);
      mem_ce_n   <= !active_nxt;
      mem_we_n   <= (st_nxt != ST_WSTROBE);
      mem_oe_n   <= (st_nxt != ST_READ);
      mem_bsel_n <= active_nxt ? ~lane_en_nxt : '1;
      if (accept) begin
        mem_addr  <= req_addr;
        lane_en_q <= req_be;
        last_rd_q <= !req_write;
      end
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 20000,
  parameter int T_AA_PS   = 55000,
  parameter int T_WC_PS   = 55000,
  parameter int T_WP_PS   = 30000,
  parameter int T_DW_PS   = 25000,
  parameter int T_OHZ_PS  = 25000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic [DATA_W/8-1:0]   mem_bsel_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic [DATA_W/8-1:0]   mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int LANE_W  = 8;
  localparam int BE_W    = DATA_W / LANE_W;
  localparam int AA_CYC  = cycles_for(T_AA_PS, CLK_PS);
  localparam int WP_CYC  = max_of(cycles_for(T_WP_PS, CLK_PS),
                                  cycles_for(T_DW_PS, CLK_PS));
  localparam int WC_CYC  = cycles_for(T_WC_PS, CLK_PS);
  localparam int REC_CYC = max_of(1, WC_CYC - 1 - WP_CYC);
  localparam int OHZ_CYC = cycles_for(T_OHZ_PS, CLK_PS);
  localparam int MAX_CYC = max_of(max_of(AA_CYC, WP_CYC), max_of(REC_CYC, OHZ_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_zero;
  logic             accept;
  logic             drive_nxt;
  logic [BE_W-1:0]  lane_en_nxt;
  logic             capture;
  logic [BE_W-1:0]  lane_en_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .zero     (timer_zero)
  );

  sram_seq_fsm #(
    .ADDR_W  (ADDR_W),
    .BE_W    (BE_W),
    .CNT_W   (CNT_W),
    .AA_CYC  (AA_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .OHZ_CYC (OHZ_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_ready   (req_ready),
    .mem_addr    (mem_addr),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_bsel_n  (mem_bsel_n),
    .timer_load  (timer_load),
    .timer_val   (timer_val),
    .timer_zero  (timer_zero),
    .accept      (accept),
    .drive_nxt   (drive_nxt),
    .lane_en_nxt (lane_en_nxt),
    .capture     (capture),
    .lane_en_q   (lane_en_q)
  );

  sram_lane_io #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .BE_W   (BE_W)
  ) u_lanes (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_wdata   (req_wdata),
    .drive_nxt   (drive_nxt),
    .lane_en_nxt (lane_en_nxt),
    .capture     (capture),
    .lane_en_q   (lane_en_q),
    .mem_dq_in   (mem_dq_in),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W  = 17,
  parameter int BE_W    = 2,
  parameter int WP_CYC  = 2,
  parameter int OHZ_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [BE_W-1:0]   mem_bsel_n,
  input logic [BE_W-1:0]   mem_dq_oe
);

  logic [15:0] we_low_q;
  logic [15:0] oe_idle_q;

  // cycles write enable has been low, and cycles since output enable was last low
  always_ff @(posedge clk) begin
    if (rst) begin
      we_low_q  <= '0;
      oe_idle_q <= 16'hFFFF;
    end else begin
      if (!mem_we_n) we_low_q <= (we_low_q == 16'hFFFF) ? we_low_q : we_low_q + 1'b1;
      else           we_low_q <= '0;
      if (!mem_oe_n) oe_idle_q <= '0;
      else           oe_idle_q <= (oe_idle_q == 16'hFFFF) ? oe_idle_q : oe_idle_q + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (req_ready && mem_ce_n && mem_we_n && mem_oe_n && (&mem_bsel_n)
             && (mem_dq_oe == '0) && !rsp_valid));

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r2_result_ends_read: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(mem_oe_n) == 1'b0 && mem_oe_n));

  a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  a_r3_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_q >= 16'(WP_CYC)));

  a_r4_drive_window: assert property (@(posedge clk) disable iff (rst)
    (|mem_dq_oe) |-> (!mem_ce_n && mem_oe_n));

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_bsel_n)));

  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(|mem_dq_oe) |-> (oe_idle_q >= 16'(OHZ_CYC)));

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && (mem_dq_oe == '0)));

endmodule

bind sram_strobe_ctrl sram_ctrl_checker #(
  .ADDR_W  (ADDR_W),
  .BE_W    (BE_W),
  .WP_CYC  (WP_CYC),
  .OHZ_CYC (OHZ_CYC)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_bsel_n (mem_bsel_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_test.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_test;

  localparam int AW     = 6;
  localparam int DW     = 16;
  localparam int WORDS  = 1 << AW;
  localparam int CLK_PS = 20000;
  localparam int TAA    = 55000;
  localparam int TWC    = 55000;
  localparam int TWP    = 30000;
  localparam int TDW    = 25000;
  localparam int TOHZ   = 25000;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  localparam int E_AA   = cdiv(TAA, CLK_PS);
  localparam int E_WP   = (cdiv(TWP, CLK_PS) > cdiv(TDW, CLK_PS)) ? cdiv(TWP, CLK_PS) : cdiv(TDW, CLK_PS);
  localparam int E_WC   = cdiv(TWC, CLK_PS);
  localparam int E_REC  = (E_WC - 1 - E_WP > 1) ? (E_WC - 1 - E_WP) : 1;
  localparam int E_WR   = 1 + E_WP + E_REC;
  localparam int E_TURN = cdiv(TOHZ, CLK_PS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]    mem_bsel_n;
  logic [DW-1:0] mem_dq_out;
  logic [1:0]    mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  always #10 clk = ~clk;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .T_AA_PS(TAA), .T_WC_PS(TWC),
    .T_WP_PS(TWP), .T_DW_PS(TDW), .T_OHZ_PS(TOHZ)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model, sampled at falling clock edges ----------------
  logic [DW-1:0] model_mem [WORDS];
  logic [DW-1:0] ref_mem   [WORDS];
  int            rd_stable, we_low, d_setup;
  logic          rd_prev;
  logic [AW-1:0] addr_prev, wr_addr;
  logic [1:0]    bsel_prev, wr_lanes, wr_drv;
  logic [DW-1:0] wr_data;
  logic          rd_now;

  assign rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (rd_now && !mem_bsel_n[i])
        mem_dq_in[i*8 +: 8] = (rd_stable * CLK_PS >= TAA) ? model_mem[mem_addr][i*8 +: 8] : 8'hEE;
      else
        mem_dq_in[i*8 +: 8] = 8'hA5;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      rd_stable = 0; we_low = 0; d_setup = 0; rd_prev = 1'b0;
      addr_prev = '0; bsel_prev = '1;
    end else begin
      if (rd_now && rd_prev && mem_addr == addr_prev && mem_bsel_n == bsel_prev)
        rd_stable = rd_stable + 1;
      else
        rd_stable = rd_now ? 1 : 0;
      if (!mem_we_n) begin
        if (we_low > 0) chk(mem_addr == addr_prev && mem_bsel_n == bsel_prev, "R5 addr/lanes moved under write enable",
                            {26'd0, mem_addr}, {26'd0, addr_prev});
        chk(!mem_ce_n && mem_oe_n, "R3 write enable outside chip enable", {30'd0, mem_ce_n, mem_oe_n}, 32'h1);
        we_low = we_low + 1;
        if (mem_dq_oe == ~mem_bsel_n) d_setup = d_setup + 1;
        wr_data = mem_dq_out; wr_lanes = mem_bsel_n; wr_drv = mem_dq_oe; wr_addr = mem_addr;
      end else if (we_low != 0) begin
        chk(we_low * CLK_PS >= TWP, "R3 write pulse width", we_low, E_WP);
        chk(d_setup * CLK_PS >= TDW, "R4 data valid before write end", d_setup, E_WP);
        for (int i = 0; i < 2; i++)
          if (!wr_lanes[i]) model_mem[wr_addr][i*8 +: 8] = wr_drv[i] ? wr_data[i*8 +: 8] : 8'h5C;
        we_low = 0; d_setup = 0;
      end
      if (|mem_dq_oe) chk(!rd_now && (mem_dq_oe & mem_bsel_n) == 2'b00, "R4 drive conflicts",
                          {28'd0, mem_dq_oe, mem_bsel_n}, 32'h0);
      rd_prev = rd_now; addr_prev = mem_addr; bsel_prev = mem_bsel_n;
    end
  end

  // ---------------- request driver ----------------
  bit last_rd = 1'b0;

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int lat;
    int exp_lat;
    string tag;
    logic [DW-1:0] exp;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!req_ready && lat < 64) begin
      lat++;
      chk(!rsp_valid, "R2 result strobe while busy", {31'd0, rsp_valid}, 32'h0);
      if (!mem_ce_n) chk(mem_bsel_n == ~be, "R6 lane select mapping", {30'd0, mem_bsel_n}, {30'd0, ~be});
      @(negedge clk);
    end
    exp_lat = wr ? (E_WR + (last_rd ? E_TURN : 0)) : E_AA;
    tag = wr ? (last_rd ? "R7 write after read occupancy" : "R8 write occupancy") : "R9 read occupancy";
    chk(lat == exp_lat, tag, lat, exp_lat);
    if (wr) begin
      chk(!rsp_valid, "R2 no result for write", {31'd0, rsp_valid}, 32'h0);
      for (int i = 0; i < 2; i++) if (be[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
    end else begin
      exp = ref_mem[a];
      for (int i = 0; i < 2; i++) if (!be[i]) exp[i*8 +: 8] = 8'h00;
      chk(rsp_valid, "R2 result strobe", {31'd0, rsp_valid}, 32'h1);
      chk(rsp_data == exp, (be == 2'b11) ? "R2 read data" : "R10 masked read data", {16'd0, rsp_data}, {16'd0, exp});
    end
    last_rd = !wr;
  endtask

  function automatic logic [DW-1:0] pat_a(input int a);
    return 16'((a * 16'h0403) ^ 16'h5A3C);
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      model_mem[i] = 16'h0000; ref_mem[i] = 16'h0000;
    end
    repeat (4) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_bsel_n == 2'b11 && mem_dq_oe == 2'b00 && !rsp_valid,
        "R1 state in reset", {26'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n}, 32'h3F);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_bsel_n == 2'b11 && mem_dq_oe == 2'b00 && !rsp_valid,
        "R1 state after reset", {26'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_bsel_n}, 32'h3F);

    // full-word fill and read-back sweep
    for (int a = 0; a < WORDS; a++) run_op(1'b1, AW'(a), pat_a(a), 2'b11);
    for (int a = 0; a < WORDS; a++) run_op(1'b0, AW'(a), 16'h0, 2'b11);

    // partial-lane writes interleaved with masked reads (write after read each time)
    for (int a = 0; a < WORDS; a++) begin
      run_op(1'b1, AW'(a), ~pat_a(a) + 16'(a), 2'((a % 3) + 1));
      run_op(1'b0, AW'(a), 16'h0, 2'(((a + 1) % 3) + 1));
    end

    // full read-back after lane merges, then reads with no lane enabled
    for (int a = 0; a < WORDS; a++) run_op(1'b0, AW'(a), 16'h0, 2'b11);
    for (int a = 0; a < 4; a++) run_op(1'b0, AW'(a * 7), 16'h0, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule